// File: doc/BRIEF.md
# Embedded Controller Byte-Protocol Slave Engine

This block runs the message protocol between a host and an embedded controller that owns an I2C bus as master. The bit-level I2C interface is outside the block. Each completed bus byte reaches the engine as one event strobe. The strobe carries three flags and a data byte:

- `ev_start`: the byte is an address or start byte.
- `ev_rnw`: the master is reading.
- `ev_end`: the transfer has ended.

A five-state sequencer reads these events. It stores the bytes the controller writes into a receive RAM. It checks a completed message against the length encoded in the message's own header. When the controller reads, the engine returns bytes from the transmit message that the host has queued.

The host tells the controller it has something to send with an active-low request line. To queue a message, the host fills the transmit RAM, then pulses a load strobe with the message length. The engine pulls the request line low and holds the message until a read transfer takes it in full. The engine raises `done` when a host message is delivered or when a non-event message is received. The host uses this pulse to move to its next message. If no message is queued when the controller reads, the engine answers with a fixed no-op message. If a read ends early, the engine asks again.

Top module: `ecx_slave_engine`

## Requirements
- R1: After reset, `req_n` is 1 and `rd_stb`, `err`, `done` and `rx_valid` are 0.
- R2: An address event (`ev_start`=1, `ev_rnw`=0, `ev_end`=0) whose byte is not equal to `slave_addr` pulses `err`. The transfer still proceeds into the command phase.
- R3: Before any address event, any other event pulses `err`, and the engine stays waiting for an address. A data byte seen there is never taken as a command.
- R4: A write transfer has an address, a command byte, a header byte and payload, and ends with an end event (`ev_end`=1, `ev_rnw`=0). Bytes are stored in order from RAM index 0. If the count is correct, `rx_valid` pulses with `rx_len` equal to the byte count. `done` also pulses when bit 7 of byte 0 is 0.
- R5: Expected length comes from byte 0 (b0) and byte 1 (b1):
  - If b0[7]=0, or b0[6:5]=2, the length is b1+2.
  - If b0[7]=1 and b0[6:5]=0, the length is 2.
  - If b0[7]=1 and b0[6:5]=1, the length is 3.
  - If b0[7]=1 and b0[6:5]=3, no length matches.

  On a mismatch the message is discarded: `err` pulses and `rx_valid` does not. A good message with b0[7]=1 gives no `done`.
- R6: A read start (`ev_start`=1, `ev_rnw`=1) right after the command byte is legal only if the command was 0x01. Otherwise `err` pulses, 0xFF is sent, and the engine drops back to waiting for an address.
- R7: `tx_load` pulls `req_n` low. A legal read start sends transmit byte 0 and raises `req_n`. Each further read (`ev_rnw`=1, `ev_start`=0) sends the next byte. An end event after all bytes pulses `done`. Every read event produces a `rd_stb` pulse one cycle later.
- R8: An end event during a read, arriving before all bytes are sent, pulls `req_n` low again without `done`. The next read transfer restarts from byte 0.
- R9: With no message queued, a read transfer receives 0x02, 0x07, 0x02. This gives no `done` and leaves `req_n` high.
- R10: Reading past the end of the message returns 0xFF and pulses `err`.
- R11: Payload beyond `MSG_MAX` bytes pulses `err` and is not stored. `rx_len` never exceeds `MSG_MAX`.
- R12: An unexpected flag pattern after the address phase pulses `err`, and the engine returns to waiting for an address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slave_addr | input | 8 | Expected address byte |
| ev_valid | input | 1 | Byte event strobe |
| ev_start | input | 1 | Event is an address/start byte |
| ev_rnw | input | 1 | Master is reading |
| ev_end | input | 1 | Transfer ended |
| ev_data | input | 8 | Byte written by the master |
| rd_byte | output | 8 | Byte to return to the master |
| rd_stb | output | 1 | `rd_byte` is valid for this read event |
| tx_we | input | 1 | Transmit RAM write enable |
| tx_waddr | input | TAW | Transmit RAM write index |
| tx_wdata | input | 8 | Transmit RAM write byte |
| tx_load | input | 1 | Queue the message now in the transmit RAM |
| tx_len | input | TPW | Length of the queued message |
| req_n | output | 1 | Active-low request line to the controller |
| rx_rd_addr | input | RAW | Receive RAM read index |
| rx_rd_data | output | 8 | Receive RAM byte, one cycle after the index |
| rx_valid | output | 1 | A received message passed its length check |
| rx_len | output | RPW | Byte count of that message |
| done | output | 1 | Host message delivered or non-event message received |
| err | output | 1 | Protocol error pulse |

## Verification
The bench targets the fork after the command byte, which has four outcomes:
- A legal read start.
- A read start after the wrong command, which must send filler and not leak message data.
- A header byte.
- A stray flag, which must send the engine back to idle rather than let it go on storing.

Each header length code is tested, including the reserved code. A design that mixes up the codes would accept short events or discard valid ones. A premature end must lower the request line and restart the message at byte 0; a design that resumes mid-message, or reports delivery, fails those checks. The empty-queue no-op, the underflow filler and the receive cap are each tested at their exact boundary byte.

// File: rtl/ecx_pkg.sv
package ecx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CMD  = 3'd1,
    ST_FORK = 3'd2,
    ST_SEND = 3'd3,
    ST_RECV = 3'd4
  } ecx_state_e;

  localparam logic [7:0] CMD_READ  = 8'h01;
  localparam logic [7:0] FILL_BYTE = 8'hFF;
  localparam logic [7:0] NOOP_OUT  = 8'h02;
  localparam logic [7:0] NOOP_MID  = 8'h07;

  localparam logic [1:0] SZ_TWO   = 2'd0;
  localparam logic [1:0] SZ_THREE = 2'd1;
  localparam logic [1:0] SZ_VAR   = 2'd2;
endpackage

// File: rtl/ecx_byte_ram.sv
module ecx_byte_ram #(
  parameter int DEPTH = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/ecx_len_calc.sv
module ecx_len_calc
  import ecx_pkg::*;
(
  input  logic [7:0] hdr0,
  input  logic [7:0] hdr1,
  output logic [8:0] exp_len,
  output logic       is_event
);
  always_comb begin
    is_event = hdr0[7];
    if (!hdr0[7] || hdr0[6:5] == SZ_VAR)
      exp_len = {1'b0, hdr1} + 9'd2;
    else if (hdr0[6:5] == SZ_TWO)
      exp_len = 9'd2;
    else if (hdr0[6:5] == SZ_THREE)
      exp_len = 9'd3;
    else
      exp_len = 9'd0;
  end
endmodule

// File: rtl/ecx_slave_engine.sv
module ecx_slave_engine
  import ecx_pkg::*;
#(
  parameter int MSG_MAX  = 32,
  parameter int TX_DEPTH = 32,
  localparam int RAW = $clog2(MSG_MAX),
  localparam int RPW = $clog2(MSG_MAX + 1),
  localparam int TAW = $clog2(TX_DEPTH),
  localparam int TPW = $clog2(TX_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [7:0]     slave_addr,
  input  logic           ev_valid,
  input  logic           ev_start,
  input  logic           ev_rnw,
  input  logic           ev_end,
  input  logic [7:0]     ev_data,
  output logic [7:0]     rd_byte,
  output logic           rd_stb,
  input  logic           tx_we,
  input  logic [TAW-1:0] tx_waddr,
  input  logic [7:0]     tx_wdata,
  input  logic           tx_load,
  input  logic [TPW-1:0] tx_len,
  output logic           req_n,
  input  logic [RAW-1:0] rx_rd_addr,
  output logic [7:0]     rx_rd_data,
  output logic           rx_valid,
  output logic [RPW-1:0] rx_len,
  output logic           done,
  output logic           err
);
  localparam logic [RPW-1:0] RX_CAP   = RPW'(MSG_MAX);
  localparam logic [TPW-1:0] NOOP_LEN = TPW'(3);

  ecx_state_e     state;
  logic [RPW-1:0] rx_pos;
  logic [TPW-1:0] tx_pos, tx_size;
  logic           tx_pending, noop_active;
  logic [7:0]     hdr0, hdr1;

  // event classification
  logic is_addr, is_plain, is_rdstart, wants_byte;
  assign is_addr    = ev_valid &  ev_start & ~ev_rnw & ~ev_end;
  assign is_plain   = ev_valid & ~ev_start & ~ev_rnw & ~ev_end;
  assign is_rdstart = ev_valid &  ev_start &  ev_rnw & ~ev_end;
  assign wants_byte = ev_valid &  ev_rnw   & ~ev_end;

  // receive storage: written at the running position
  logic rx_we;
  assign rx_we = is_plain && ((state == ST_CMD) || (state == ST_FORK) ||
                              ((state == ST_RECV) && (rx_pos < RX_CAP)));

  ecx_byte_ram #(.DEPTH(MSG_MAX)) u_rx_ram (
    .clk   (clk),
    .we    (rx_we),
    .waddr (rx_pos[RAW-1:0]),
    .wdata (ev_data),
    .raddr (rx_rd_addr),
    .rdata (rx_rd_data)
  );

  // transmit storage: read port prefetches the next byte to send
  logic [7:0]     tx_q;
  logic [TAW-1:0] tx_raddr;
  assign tx_raddr = (state == ST_FORK) ? '0 : tx_pos[TAW-1:0];

  ecx_byte_ram #(.DEPTH(TX_DEPTH)) u_tx_ram (
    .clk   (clk),
    .we    (tx_we),
    .waddr (tx_waddr),
    .wdata (tx_wdata),
    .raddr (tx_raddr),
    .rdata (tx_q)
  );

  logic [8:0] exp_len;
  logic       is_event;
  ecx_len_calc u_len (
    .hdr0     (hdr0),
    .hdr1     (hdr1),
    .exp_len  (exp_len),
    .is_event (is_event)
  );

  logic [7:0]     tx_cur;
  logic [TPW-1:0] cur_size;
  assign tx_cur   = noop_active ? ((tx_pos == TPW'(1)) ? NOOP_MID : NOOP_OUT) : tx_q;
  assign cur_size = noop_active ? NOOP_LEN : tx_size;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      rx_pos      <= '0;
      tx_pos      <= '0;
      tx_size     <= '0;
      tx_pending  <= 1'b0;
      noop_active <= 1'b0;
      hdr0        <= '0;
      hdr1        <= '0;
      rd_byte     <= FILL_BYTE;
      rd_stb      <= 1'b0;
      req_n       <= 1'b1;
      rx_valid    <= 1'b0;
      rx_len      <= '0;
      done        <= 1'b0;
      err         <= 1'b0;
    end else begin
      rd_stb   <= 1'b0;
      rx_valid <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;

      if (tx_load && !tx_pending) begin
        tx_pending <= 1'b1;
        tx_size    <= tx_len;
        req_n      <= 1'b0;
      end

      if (wants_byte) begin
        rd_stb  <= 1'b1;
        rd_byte <= FILL_BYTE;
      end

      if (ev_valid) begin
        if (is_addr) begin
          if (ev_data != slave_addr) err <= 1'b1;
          rx_pos <= '0;
          state  <= ST_CMD;
        end else begin
          unique case (state)
            ST_IDLE: err <= 1'b1;

            ST_CMD: begin
              if (is_plain) begin
                hdr0   <= ev_data;
                rx_pos <= RPW'(1);
                state  <= ST_FORK;
              end else begin
                err   <= 1'b1;
                state <= ST_IDLE;
              end
            end

            ST_FORK: begin
              if (is_rdstart) begin
                if (hdr0 == CMD_READ) begin
                  rd_byte     <= tx_pending ? tx_q : NOOP_OUT;
                  noop_active <= !tx_pending;
                  tx_pos      <= TPW'(1);
                  req_n       <= 1'b1;
                  state       <= ST_SEND;
                end else begin
                  err   <= 1'b1;
                  state <= ST_IDLE;
                end
              end else if (is_plain) begin
                hdr1   <= ev_data;
                rx_pos <= RPW'(2);
                state  <= ST_RECV;
              end else begin
                err   <= 1'b1;
                state <= ST_IDLE;
              end
            end

            ST_SEND: begin
              if (ev_end) begin
                state <= ST_IDLE;
                if (tx_pos != cur_size) begin
                  err   <= 1'b1;
                  req_n <= 1'b0;
                end else begin
                  noop_active <= 1'b0;
                  if (!noop_active) begin
                    tx_pending <= 1'b0;
                    done       <= 1'b1;
                  end
                end
              end else if (!ev_rnw || ev_start) begin
                err   <= 1'b1;
                state <= ST_IDLE;
              end else if (tx_pos < cur_size) begin
                rd_byte <= tx_cur;
                tx_pos  <= tx_pos + TPW'(1);
              end else begin
                err <= 1'b1;
              end
            end

            ST_RECV: begin
              if (ev_end && !ev_rnw) begin
                state <= ST_IDLE;
                if (exp_len == 9'(rx_pos)) begin
                  rx_valid <= 1'b1;
                  rx_len   <= rx_pos;
                  if (!is_event) done <= 1'b1;
                end else begin
                  err <= 1'b1;
                end
              end else if (ev_rnw || ev_start) begin
                err   <= 1'b1;
                state <= ST_IDLE;
              end else if (rx_pos < RX_CAP) begin
                rx_pos <= rx_pos + RPW'(1);
              end else begin
                err <= 1'b1;
              end
            end

            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/ecx_slave_engine_chk.sv
module ecx_slave_engine_chk #(
  parameter int MSG_MAX = 32,
  localparam int RPW = $clog2(MSG_MAX + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           ev_valid,
  input logic           ev_rnw,
  input logic           ev_end,
  input logic           tx_load,
  input logic           rd_stb,
  input logic           req_n,
  input logic           done,
  input logic           rx_valid,
  input logic           err,
  input logic [RPW-1:0] rx_len
);
  p_send_on_read_r7: assert property (@(posedge clk) disable iff (rst)
    (ev_valid && ev_rnw && !ev_end) |=> rd_stb);

  p_quiet_on_write_r4: assert property (@(posedge clk) disable iff (rst)
    !(ev_valid && ev_rnw && !ev_end) |=> !rd_stb);

  p_done_after_end_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(ev_valid && ev_end));

  p_req_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(req_n) |-> $past(ev_valid && ev_rnw));

  p_req_fall_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(req_n) |-> $past(tx_load || (ev_valid && ev_end)));

  p_len_cap_r11: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> (rx_len <= RPW'(MSG_MAX)));

  p_valid_or_err_r5: assert property (@(posedge clk) disable iff (rst)
    !(rx_valid && err));
endmodule

bind ecx_slave_engine ecx_slave_engine_chk #(.MSG_MAX(MSG_MAX)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .ev_valid (ev_valid),
  .ev_rnw   (ev_rnw),
  .ev_end   (ev_end),
  .tx_load  (tx_load),
  .rd_stb   (rd_stb),
  .req_n    (req_n),
  .done     (done),
  .rx_valid (rx_valid),
  .err      (err),
  .rx_len   (rx_len)
);

// File: tb/sim_ecx_slave_engine.sv
`timescale 1ns/1ps
module sim_ecx_slave_engine;
  localparam int MSG_MAX  = 32;
  localparam int TX_DEPTH = 32;
  localparam int RAW = $clog2(MSG_MAX);
  localparam int RPW = $clog2(MSG_MAX + 1);
  localparam int TAW = $clog2(TX_DEPTH);
  localparam int TPW = $clog2(TX_DEPTH + 1);
  localparam logic [7:0] ADDR = 8'h8A;

  logic clk = 1'b0, rst = 1'b1;
  logic ev_valid = 0, ev_start = 0, ev_rnw = 0, ev_end = 0;
  logic [7:0] ev_data = '0;
  logic tx_we = 0, tx_load = 0;
  logic [TAW-1:0] tx_waddr = '0;
  logic [7:0] tx_wdata = '0;
  logic [TPW-1:0] tx_len = '0;
  logic [RAW-1:0] rx_rd_addr = '0;
  logic [7:0] rd_byte, rx_rd_data;
  logic rd_stb, req_n, rx_valid, done, err;
  logic [RPW-1:0] rx_len;

  int nchk = 0, nbad = 0;
  bit finished = 0;
  // outputs captured after each event
  int s_stb, s_byte, s_err, s_done, s_val, s_len, s_req;

  always #4 clk = ~clk;

  ecx_slave_engine #(.MSG_MAX(MSG_MAX), .TX_DEPTH(TX_DEPTH)) u0 (
    .clk(clk), .rst(rst), .slave_addr(ADDR),
    .ev_valid(ev_valid), .ev_start(ev_start), .ev_rnw(ev_rnw), .ev_end(ev_end),
    .ev_data(ev_data), .rd_byte(rd_byte), .rd_stb(rd_stb),
    .tx_we(tx_we), .tx_waddr(tx_waddr), .tx_wdata(tx_wdata),
    .tx_load(tx_load), .tx_len(tx_len), .req_n(req_n),
    .rx_rd_addr(rx_rd_addr), .rx_rd_data(rx_rd_data),
    .rx_valid(rx_valid), .rx_len(rx_len), .done(done), .err(err)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ev(input bit st, input bit r, input bit e, input logic [7:0] d);
    @(negedge clk);
    ev_valid = 1; ev_start = st; ev_rnw = r; ev_end = e; ev_data = d;
    @(negedge clk);
    ev_valid = 0; ev_start = 0; ev_rnw = 0; ev_end = 0;
    s_stb = rd_stb; s_byte = rd_byte; s_err = err; s_done = done;
    s_val = rx_valid; s_len = int'(rx_len); s_req = req_n;
  endtask

  task automatic rx_peek(input int idx, output int val);
    @(negedge clk); rx_rd_addr = RAW'(idx);
    @(negedge clk); val = rx_rd_data;
  endtask

  task automatic load_msg(input logic [7:0] b0, b1, b2, input int n);
    logic [7:0] bs [3];
    bs[0] = b0; bs[1] = b1; bs[2] = b2;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tx_we = 1; tx_waddr = TAW'(i); tx_wdata = bs[i];
    end
    @(negedge clk); tx_we = 0; tx_load = 1; tx_len = TPW'(n);
    @(negedge clk); tx_load = 0;
  endtask

  task automatic t_reset;
    chk("R1 req_n", req_n, 1);
    chk("R1 rd_stb", rd_stb, 0);
    chk("R1 err", err, 0);
    chk("R1 done", done, 0);
    chk("R1 rx_valid", rx_valid, 0);
  endtask

  task automatic t_write;
    int v;
    ev(1,0,0,ADDR); chk("R4 addr ok", s_err, 0);
    ev(0,0,0,8'h03); ev(0,0,0,8'h02); ev(0,0,0,8'hAA); ev(0,0,0,8'hBB);
    chk("R4 no read strobe", s_stb, 0);
    ev(0,0,1,8'h00);
    chk("R4 valid", s_val, 1); chk("R4 len", s_len, 4); chk("R4 done", s_done, 1);
    rx_peek(0, v); chk("R4 byte0", v, 8'h03);
    rx_peek(3, v); chk("R4 byte3", v, 8'hBB);
  endtask

  task automatic t_lengths;
    ev(1,0,0,ADDR); ev(0,0,0,8'h80); ev(0,0,0,8'h11); ev(0,0,1,0);
    chk("R5 fixed2 valid", s_val, 1); chk("R5 fixed2 len", s_len, 2);
    chk("R5 event no done", s_done, 0);
    ev(1,0,0,ADDR); ev(0,0,0,8'hA0); ev(0,0,0,8'h11); ev(0,0,1,0);
    chk("R5 fixed3 short discarded", s_val, 0); chk("R5 fixed3 err", s_err, 1);
    ev(1,0,0,ADDR); ev(0,0,0,8'hA0); ev(0,0,0,8'h11); ev(0,0,0,8'h12); ev(0,0,1,0);
    chk("R5 fixed3 valid", s_val, 1); chk("R5 fixed3 len", s_len, 3);
    ev(1,0,0,ADDR); ev(0,0,0,8'hC0); ev(0,0,0,8'h01); ev(0,0,0,8'h55); ev(0,0,1,0);
    chk("R5 var event valid", s_val, 1); chk("R5 var event len", s_len, 3);
    ev(1,0,0,ADDR); ev(0,0,0,8'hE0); ev(0,0,0,8'h00); ev(0,0,1,0);
    chk("R5 reserved discarded", s_val, 0); chk("R5 reserved err", s_err, 1);
  endtask

  task automatic t_addr_mismatch;
    ev(1,0,0,8'h44); chk("R2 mismatch err", s_err, 1);
    ev(0,0,0,8'h03); chk("R2 cmd accepted", s_err, 0);
    ev(0,0,0,8'h00); ev(0,0,1,0);
    chk("R2 transfer still completes", s_val, 1);
  endtask

  task automatic t_idle_flags;
    ev(0,0,0,8'h03); chk("R3 data in idle err", s_err, 1);
    ev(0,0,0,8'h00); chk("R3 still idle err", s_err, 1);
    ev(0,0,1,0); chk("R3 end in idle err", s_err, 1);
    chk("R3 no message", s_val, 0);
  endtask

  task automatic t_unexpected;
    ev(1,0,0,ADDR); ev(0,0,1,0); chk("R12 end in cmd err", s_err, 1);
    ev(0,0,0,8'h03); chk("R12 back to idle", s_err, 1);
    ev(1,0,0,ADDR); ev(0,0,0,8'h03); ev(0,0,0,8'h01);
    ev(0,1,0,0); chk("R12 read in recv err", s_err, 1);
    chk("R12 filler sent", s_byte, 8'hFF);
    ev(0,0,0,8'h77); chk("R12 recv abandoned", s_err, 1);
  endtask

  task automatic t_read;
    load_msg(8'h03, 8'h21, 8'h22, 3);
    chk("R7 req low after load", req_n, 0);
    ev(1,0,0,ADDR); ev(0,0,0,8'h01);
    ev(1,1,0,ADDR|8'h01);
    chk("R7 first strobe", s_stb, 1); chk("R7 first byte", s_byte, 8'h03);
    chk("R7 req released", s_req, 1);
    ev(0,1,0,0); chk("R7 second byte", s_byte, 8'h21);
    ev(0,1,0,0); chk("R7 third byte", s_byte, 8'h22);
    ev(0,1,1,0); chk("R7 done", s_done, 1); chk("R7 no err", s_err, 0);
    chk("R7 req stays high", s_req, 1);
  endtask

  task automatic t_bad_read_cmd;
    ev(1,0,0,ADDR); ev(0,0,0,8'h05); ev(1,1,0,0);
    chk("R6 wrong cmd err", s_err, 1); chk("R6 filler", s_byte, 8'hFF);
    ev(0,1,0,0); chk("R6 back to idle", s_err, 1);
  endtask

  task automatic t_premature;
    load_msg(8'h03, 8'h31, 8'h32, 3);
    ev(1,0,0,ADDR); ev(0,0,0,8'h01); ev(1,1,0,0);
    chk("R8 byte0", s_byte, 8'h03);
    ev(0,1,1,0);
    chk("R8 no done", s_done, 0); chk("R8 req low again", s_req, 0);
    ev(1,0,0,ADDR); ev(0,0,0,8'h01); ev(1,1,0,0);
    chk("R8 restart byte0", s_byte, 8'h03);
    ev(0,1,0,0); chk("R8 byte1", s_byte, 8'h31);
    ev(0,1,0,0); chk("R8 byte2", s_byte, 8'h32);
    ev(0,1,1,0); chk("R8 done after resend", s_done, 1);
  endtask

  task automatic t_underflow;
    load_msg(8'h02, 8'h41, 8'h00, 2);
    ev(1,0,0,ADDR); ev(0,0,0,8'h01); ev(1,1,0,0);
    ev(0,1,0,0); chk("R10 last byte", s_byte, 8'h41);
    ev(0,1,0,0); chk("R10 filler", s_byte, 8'hFF); chk("R10 err", s_err, 1);
    ev(0,1,1,0); chk("R10 done", s_done, 1);
  endtask

  task automatic t_noop;
    ev(1,0,0,ADDR); ev(0,0,0,8'h01); ev(1,1,0,0);
    chk("R9 noop0", s_byte, 8'h02); chk("R9 req high", s_req, 1);
    ev(0,1,0,0); chk("R9 noop1", s_byte, 8'h07);
    ev(0,1,0,0); chk("R9 noop2", s_byte, 8'h02);
    ev(0,1,1,0); chk("R9 no done", s_done, 0); chk("R9 no err", s_err, 0);
  endtask

  task automatic t_overflow;
    int v;
    ev(1,0,0,ADDR); ev(0,0,0,8'h03); ev(0,0,0,8'(MSG_MAX - 2));
    for (int i = 0; i < MSG_MAX - 2; i++) ev(0,0,0,8'h40 + 8'(i));
    chk("R11 fill no err", s_err, 0);
    ev(0,0,0,8'hEE); chk("R11 overflow err", s_err, 1);
    ev(0,0,1,0);
    chk("R11 valid", s_val, 1); chk("R11 len capped", s_len, MSG_MAX);
    rx_peek(MSG_MAX - 1, v); chk("R11 last stored", v, 8'h40 + MSG_MAX - 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_write;
    t_lengths;
    t_addr_mismatch;
    t_idle_flags;
    t_unexpected;
    t_read;
    t_bad_read_cmd;
    t_premature;
    t_underflow;
    t_noop;
    t_overflow;
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++; nbad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule